// File: doc/BRIEF.md
# Gated Attention Map Blender

This block merges two streams of 8-bit quantized attention probabilities into one. One stream carries content scores and the other carries position scores. Each output element is `(1-g)*A + g*B`, where `g` is a per-head mixing weight. Software computes that weight and supplies it as an 8-bit fraction, so the datapath contains no sigmoid. The blended value is rounded back to 8 bits. The block does not compute the softmax or the score products that feed it.

Software starts each head with a one-cycle start pulse. With that pulse it presents the head's gate and the head index, and the block latches both for the rest of the head. When the gate is at either end of its range, the block does not use the branch that has zero weight. It raises a skip pulse, holds that branch's ready low and passes the other stream through unchanged. This frees the upstream producer of the unused branch from having to deliver data.

Back-pressure rules: every stream is valid/ready, and a transfer happens on a clock edge where both valid and ready are high. The output register accepts a new result when it is empty or when its current result is taken in the same cycle. While `res_valid` is high and `res_ready` is low, the result and its head tag stay frozen and no input is consumed. Once a producer raises valid, it must hold its data until the transfer completes.

Top module: `gate_blender`

## Requirements
- R1: When the latched gate g is 1..254, each result equals `(A*(256-G) + B*G + 128) >> 8`, with `G = g + (g >> 7)`. The constant 128 gives round-half-up.
- R2: The gate and head index are captured only on the clock edge where `head_start` is high. A change of `head_gate` at any other time has no effect on results. Each result carries the captured head index on `res_head`.
- R3: In blend mode (g from 1 to 254), a transfer happens only when both input streams are valid in the same cycle, and it consumes one element from each. If only one input is valid, its ready stays low and nothing is consumed.
- R4: A gate value of 0 selects pass-through of input A. The result equals A exactly, `pos_ready` is held low, and no B element is consumed.
- R5: A gate value of 255 selects pass-through of input B. The result equals B exactly, `cnt_ready` is held low, and no A element is consumed.
- R6: `skip_pulse` is high for exactly one cycle, the cycle after a start edge that captured gate 0 or 255. It is low after any other start edge.
- R7: While `res_valid` is high and `res_ready` is low, `res_data` and `res_head` stay stable and both input readies are low.
- R8: After reset, `res_valid` is low. Both input readies stay low until the first start edge.
- R9: When `res_ready` is held high and the inputs are valid on every cycle, one result is produced per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_start | input | 1 | One-cycle pulse that begins a head and latches gate and head index |
| head_gate | input | 8 | Mixing weight g (255 means 1.0) |
| head_id | input | HW | Head index for the head being started |
| skip_pulse | output | 1 | One-cycle pulse when the new head bypasses one branch |
| cnt_valid | input | 1 | Content-score stream valid |
| cnt_data | input | 8 | Content-score element A |
| cnt_ready | output | 1 | Content-score stream ready |
| pos_valid | input | 1 | Position-score stream valid |
| pos_data | input | 8 | Position-score element B |
| pos_ready | output | 1 | Position-score stream ready |
| res_valid | output | 1 | Result valid |
| res_data | output | 8 | Blended result |
| res_head | output | HW | Head index of the result |
| res_ready | input | 1 | Result accepted by downstream |

## Verification
Two things can happen on the same edge: the output register loads a new blended result, and a pending result is stalled or drained by the state of `res_ready`. The bench provokes this by offering an input pair while the register holds an untaken result. It then checks that neither input is consumed and that the held value does not move. After `res_ready` returns high, it checks that the next pair goes through. Mode selection and a mid-head change of the gate input can also coincide with data traffic. The bench changes `head_gate` without a start pulse while pairs are flowing, and checks that the results still follow the gate captured at the start of the head.

// File: rtl/gblend_pkg.sv
package gblend_pkg;

  typedef enum logic [1:0] {
    BM_IDLE   = 2'd0,
    BM_MIX    = 2'd1,
    BM_PASS_A = 2'd2,
    BM_PASS_B = 2'd3
  } blend_mode_e;

  // Mode chosen by a gate value of width gw.
  function automatic blend_mode_e mode_for(input logic [7:0] g);
    if (g == 8'd0)        return BM_PASS_A;
    else if (g == 8'hFF)  return BM_PASS_B;
    else                  return BM_MIX;
  endfunction

endpackage

// File: rtl/gate_capture.sv
module gate_capture
  import gblend_pkg::*;
#(
  parameter int GW = 8,
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_start,
  input  logic [GW-1:0] head_gate,
  input  logic [HW-1:0] head_id,
  output blend_mode_e   mode,
  output logic [GW-1:0] gate_q,
  output logic [HW-1:0] head_q,
  output logic          skip_pulse
);

  localparam logic [GW-1:0] GMAX = {GW{1'b1}};

  logic edge_gate;
  assign edge_gate = (head_gate == '0) || (head_gate == GMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= BM_IDLE;
      gate_q     <= '0;
      head_q     <= '0;
      skip_pulse <= 1'b0;
    end else begin
      skip_pulse <= head_start && edge_gate;
      if (head_start) begin
        gate_q <= head_gate;
        head_q <= head_id;
        if (head_gate == '0)       mode <= BM_PASS_A;
        else if (head_gate == GMAX) mode <= BM_PASS_B;
        else                        mode <= BM_MIX;
      end
    end
  end

endmodule

// File: rtl/gate_mixer.sv
module gate_mixer #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] gate,
  output logic [DW-1:0] mixed
);

  localparam int PW = 2 * DW + 2;
  localparam int unsigned ONE  = 1 << DW;
  localparam int unsigned HALF = 1 << (DW - 1);

  logic [DW:0]   g_w;
  logic [DW:0]   g_c;
  logic [PW-1:0] acc;
  logic [PW-1:0] shr;

  // Stretch 0..2^DW-1 onto 0..2^DW so the top code is exactly 1.0.
  assign g_w = {1'b0, gate} + {{DW{1'b0}}, gate[DW-1]};
  assign g_c = (DW+1)'(ONE) - g_w;

  assign acc = PW'(a_in) * PW'(g_c) + PW'(b_in) * PW'(g_w) + PW'(HALF);
  assign shr = acc >> DW;
  assign mixed = DW'(shr);

endmodule

// File: rtl/blend_stage.sv
module blend_stage
  import gblend_pkg::*;
#(
  parameter int DW = 8,
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  blend_mode_e   mode,
  input  logic [HW-1:0] head_q,
  input  logic [DW-1:0] mixed,
  input  logic          a_valid,
  input  logic [DW-1:0] a_data,
  output logic          a_ready,
  input  logic          b_valid,
  input  logic [DW-1:0] b_data,
  output logic          b_ready,
  output logic          o_valid,
  output logic [DW-1:0] o_data,
  output logic [HW-1:0] o_head,
  input  logic          o_ready
);

  logic          room;
  logic          fire;
  logic [DW-1:0] nxt;

  assign room = !o_valid || o_ready;

  always_comb begin
    a_ready = 1'b0;
    b_ready = 1'b0;
    fire    = 1'b0;
    nxt     = mixed;
    case (mode)
      BM_MIX: begin
        a_ready = room && b_valid;
        b_ready = room && a_valid;
        fire    = room && a_valid && b_valid;
        nxt     = mixed;
      end
      BM_PASS_A: begin
        a_ready = room;
        fire    = room && a_valid;
        nxt     = a_data;
      end
      BM_PASS_B: begin
        b_ready = room;
        fire    = room && b_valid;
        nxt     = b_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
      o_head  <= '0;
    end else if (fire) begin
      o_valid <= 1'b1;
      o_data  <= nxt;
      o_head  <= head_q;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/gate_blender.sv
module gate_blender
  import gblend_pkg::*;
#(
  parameter int DW = 8,
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_start,
  input  logic [DW-1:0] head_gate,
  input  logic [HW-1:0] head_id,
  output logic          skip_pulse,
  input  logic          cnt_valid,
  input  logic [DW-1:0] cnt_data,
  output logic          cnt_ready,
  input  logic          pos_valid,
  input  logic [DW-1:0] pos_data,
  output logic          pos_ready,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic [HW-1:0] res_head,
  input  logic          res_ready
);

  blend_mode_e   mode;
  logic [DW-1:0] gate_q;
  logic [HW-1:0] head_q;
  logic [DW-1:0] mixed;

  gate_capture #(.GW(DW), .HW(HW)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_start (head_start),
    .head_gate  (head_gate),
    .head_id    (head_id),
    .mode       (mode),
    .gate_q     (gate_q),
    .head_q     (head_q),
    .skip_pulse (skip_pulse)
  );

  gate_mixer #(.DW(DW)) u_mix (
    .a_in  (cnt_data),
    .b_in  (pos_data),
    .gate  (gate_q),
    .mixed (mixed)
  );

  blend_stage #(.DW(DW), .HW(HW)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .head_q  (head_q),
    .mixed   (mixed),
    .a_valid (cnt_valid),
    .a_data  (cnt_data),
    .a_ready (cnt_ready),
    .b_valid (pos_valid),
    .b_data  (pos_data),
    .b_ready (pos_ready),
    .o_valid (res_valid),
    .o_data  (res_data),
    .o_head  (res_head),
    .o_ready (res_ready)
  );

endmodule

// File: rtl/gate_blender_chk.sv
module gate_blender_chk #(
  parameter int DW = 8,
  parameter int HW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          head_start,
  input logic [DW-1:0] head_gate,
  input logic          skip_pulse,
  input logic          cnt_valid,
  input logic          cnt_ready,
  input logic          pos_valid,
  input logic          pos_ready,
  input logic          res_valid,
  input logic [DW-1:0] res_data,
  input logic [HW-1:0] res_head,
  input logic          res_ready
);

  localparam logic [DW-1:0] GMAX = {DW{1'b1}};

  logic          seen_start;
  logic [DW-1:0] gate_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_start <= 1'b0;
      gate_seen  <= '0;
    end else if (head_start) begin
      seen_start <= 1'b1;
      gate_seen  <= head_gate;
    end
  end

  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_start |-> (!cnt_ready && !pos_ready)); // R8

  AST_PASS_A_BLOCKS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_start && gate_seen == '0) |-> !pos_ready); // R4

  AST_PASS_B_BLOCKS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_start && gate_seen == GMAX) |-> !cnt_ready); // R5

  AST_MIX_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_start && gate_seen != '0 && gate_seen != GMAX && cnt_valid && cnt_ready)
      |-> (pos_valid && pos_ready)); // R3

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_head))); // R7

  AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> (!cnt_ready && !pos_ready)); // R7

  AST_SKIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    skip_pulse |-> ($past(head_start) && ($past(head_gate) == '0 || $past(head_gate) == GMAX))); // R6

endmodule

bind gate_blender gate_blender_chk #(.DW(DW), .HW(HW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .head_start (head_start),
  .head_gate  (head_gate),
  .skip_pulse (skip_pulse),
  .cnt_valid  (cnt_valid),
  .cnt_ready  (cnt_ready),
  .pos_valid  (pos_valid),
  .pos_ready  (pos_ready),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .res_head   (res_head),
  .res_ready  (res_ready)
);

// File: tb/test_gate_blender.sv
module test_gate_blender;

  localparam int DW = 8;
  localparam int HW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          head_start = 1'b0;
  logic [DW-1:0] head_gate = '0;
  logic [HW-1:0] head_id = '0;
  logic          skip_pulse;
  logic          cnt_valid = 1'b0;
  logic [DW-1:0] cnt_data = '0;
  logic          cnt_ready;
  logic          pos_valid = 1'b0;
  logic [DW-1:0] pos_data = '0;
  logic          pos_ready;
  logic          res_valid;
  logic [DW-1:0] res_data;
  logic [HW-1:0] res_head;
  logic          res_ready = 1'b1;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  gate_blender #(.DW(DW), .HW(HW)) i_gate_blender (.*);

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  function automatic int ref_mix(input int a, input int b, input int g);
    int w;
    w = g + (g / 128);
    return (a * (256 - w) + b * w + 128) / 256;
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      finish_run();
    end
  end

  // Start a head; returns skip_pulse in the cycle after and the one after that.
  task automatic start_head(input int g, input int h, output logic sp1, output logic sp2);
    @(negedge clk);
    head_start = 1'b1; head_gate = DW'(g); head_id = HW'(h);
    @(negedge clk);
    head_start = 1'b0;
    sp1 = skip_pulse;
    @(negedge clk);
    sp2 = skip_pulse;
  endtask

  // Offer one element on each chosen stream for one edge; returns readies seen.
  task automatic offer(input logic va, input int a, input logic vb, input int b,
                       output logic ra, output logic rb);
    @(negedge clk);
    cnt_valid = va; cnt_data = DW'(a);
    pos_valid = vb; pos_data = DW'(b);
    #1;
    ra = cnt_ready; rb = pos_ready;
    @(posedge clk);
    #1;
    cnt_valid = 1'b0; pos_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic ra, rb;
    offer(1'b1, 5, 1'b1, 6, ra, rb);
    chk(!ra && !rb, "R8 readies low before first start", {ra, rb}, 0);
    chk(!res_valid, "R8 res_valid low after reset", res_valid, 0);
  endtask

  task automatic t_mix();
    logic ra, rb, s1, s2;
    int ga [3] = '{64, 128, 1};
    int av [3] = '{200, 17, 255};
    int bv [3] = '{10, 250, 0};
    for (int i = 0; i < 3; i++) begin
      start_head(ga[i], i + 3, s1, s2);
      chk(!s1, "R6 no skip pulse in blend mode", s1, 0);
      offer(1'b1, av[i], 1'b1, bv[i], ra, rb);
      chk(ra && rb, "R3 both streams taken together", {ra, rb}, 3);
      chk(res_valid && res_data == DW'(ref_mix(av[i], bv[i], ga[i])),
          "R1 blended value", res_data, ref_mix(av[i], bv[i], ga[i]));
      chk(res_head == HW'(i + 3), "R2 head tag", res_head, i + 3);
    end
  endtask

  task automatic t_pairing();
    logic ra, rb, s1, s2;
    start_head(100, 1, s1, s2);
    offer(1'b1, 40, 1'b0, 0, ra, rb);
    chk(!ra, "R3 lone content element not taken", ra, 0);
    chk(!res_valid, "R3 no result from lone content element", res_valid, 0);
    offer(1'b0, 0, 1'b1, 90, ra, rb);
    chk(!rb, "R3 lone position element not taken", rb, 0);
    chk(!res_valid, "R3 no result from lone position element", res_valid, 0);
  endtask

  task automatic t_pass_a();
    logic ra, rb, s1, s2;
    start_head(0, 7, s1, s2);
    chk(s1, "R6 skip pulse after gate 0", s1, 1);
    chk(!s2, "R6 skip pulse lasts one cycle", s2, 0);
    offer(1'b1, 77, 1'b1, 99, ra, rb);
    chk(ra && !rb, "R4 only content stream taken", {ra, rb}, 2);
    chk(res_valid && res_data == 8'd77, "R4 pass-through of A", res_data, 77);
    offer(1'b0, 0, 1'b1, 55, ra, rb);
    chk(!rb && !res_valid, "R4 position stream ignored alone", {rb, res_valid}, 0);
  endtask

  task automatic t_pass_b();
    logic ra, rb, s1, s2;
    start_head(255, 9, s1, s2);
    chk(s1, "R6 skip pulse after gate 255", s1, 1);
    offer(1'b1, 12, 1'b1, 201, ra, rb);
    chk(!ra && rb, "R5 only position stream taken", {ra, rb}, 1);
    chk(res_valid && res_data == 8'd201, "R5 pass-through of B", res_data, 201);
    chk(res_head == 4'd9, "R2 head tag in pass mode", res_head, 9);
  endtask

  task automatic t_midhead();
    logic ra, rb, s1, s2;
    start_head(64, 2, s1, s2);
    @(negedge clk);
    head_gate = 8'd0; head_id = 4'd15;
    offer(1'b1, 200, 1'b1, 10, ra, rb);
    chk(ra && rb, "R2 mode unchanged by gate input mid-head", {ra, rb}, 3);
    chk(res_data == DW'(ref_mix(200, 10, 64)), "R2 latched gate still used",
        res_data, ref_mix(200, 10, 64));
    chk(res_head == 4'd2, "R2 latched head still used", res_head, 2);
  endtask

  task automatic t_backpressure();
    logic ra, rb, s1, s2;
    logic [DW-1:0] held;
    start_head(32, 4, s1, s2);
    res_ready = 1'b0;
    offer(1'b1, 100, 1'b1, 50, ra, rb);
    chk(ra && rb && res_valid, "R7 first pair captured while stalled", {ra, rb, res_valid}, 7);
    held = res_data;
    chk(held == DW'(ref_mix(100, 50, 32)), "R1 stalled value", held, ref_mix(100, 50, 32));
    offer(1'b1, 3, 1'b1, 250, ra, rb);
    chk(!ra && !rb, "R7 inputs blocked while result pending", {ra, rb}, 0);
    chk(res_valid && res_data == held, "R7 pending result stable", res_data, held);
    res_ready = 1'b1;
    offer(1'b1, 3, 1'b1, 250, ra, rb);
    chk(ra && rb, "R7 load on drain edge", {ra, rb}, 3);
    chk(res_valid && res_data == DW'(ref_mix(3, 250, 32)), "R7 next result after drain",
        res_data, ref_mix(3, 250, 32));
  endtask

  task automatic t_stream();
    logic s1, s2;
    int got = 0;
    start_head(200, 5, s1, s2);
    for (int i = 0; i <= 5; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if (res_valid && res_data == DW'(ref_mix(20 * i, 255 - 7 * i, 200))) got++;
      end
      if (i < 5) begin
        cnt_valid = 1'b1; cnt_data = DW'(20 * (i + 1));
        pos_valid = 1'b1; pos_data = DW'(255 - 7 * (i + 1));
      end else begin
        cnt_valid = 1'b0; pos_valid = 1'b0;
      end
    end
    chk(got == 5, "R9 one result per cycle", got, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!res_valid && !skip_pulse, "R8 outputs idle in reset", {res_valid, skip_pulse}, 0);
    rst_n = 1'b1;
    t_reset();
    t_mix();
    t_pairing();
    t_pass_a();
    t_pass_b();
    t_midhead();
    t_backpressure();
    t_stream();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule